// File: doc/BRIEF.md
# 8-bit Timer/Counter with Forced Compare

This block is an 8-bit timer/counter for a peripheral bus. It has four registers: control, counter, compare and flags. Two mode bits pick the counting mode. The modes are free-running count with wrap, clear-on-compare-match, single-slope PWM and dual-slope (up/down) PWM. A clock-select field takes the timer tick from a free-running divider of the system clock. On a compare match, the timer sets a flag that drives the interrupt request, and it updates a waveform output pin according to a two-bit output-action field.

Software can write a force-compare strobe in the control register. The strobe applies the output action at once, exactly as a real match would. It sets no flag and does not touch the counter. The strobe is never stored, and it has no effect in the PWM modes.

Top module: `tmr8_forced`

## Requirements
- R1: After reset, all four registers read 0, `wave_out` is 0 and `irq` is 0.
- R2: The registers sit at these addresses: control 0, counter 1, compare 2, flags 3. The control bits are: bit 7 force strobe, bit 6 mode bit A, bits 5:4 output action, bit 3 mode bit B, bits 2:0 clock select. The mode value is {B,A}: 00 free-running, 01 dual-slope PWM, 10 clear-on-match, 11 single-slope PWM. A read of control returns bit 7 as 0 and the other bits as written.
- R3: A control write with bit 7 set, whose new mode bits give a non-PWM mode, applies the new output action to the output latch in that same cycle. Action 00 leaves the latch unchanged, 01 toggles it, 10 clears it and 11 sets it. In non-PWM modes the pin shows the latch when the action is nonzero, and 0 when the action is 00.
- R4: A forced compare sets no flag, does not assert `irq`, and leaves the counter value unchanged.
- R5: In the PWM modes the force strobe leaves the output latch unchanged. In these modes, action 01 disconnects the pin (it drives 0).
- R6: In clear-on-match mode, a tick that finds counter equal to compare loads the counter with 0, sets flags bit 0 and applies the output action. The count therefore runs compare-1, compare, 0, 1.
- R7: In free-running mode the counter wraps from 255 to 0 and sets flags bit 1. `irq` follows flags bit 0 only.
- R8: Writing 1 to a bit of the flags register clears that bit. A pulse on `irq_ack` clears flags bit 0. A new set in the same cycle wins over either clear.
- R9: A counter write wins over the tick in the same cycle and blocks any match in that cycle.
- R10: Clock select 000 stops the counter, and 001 ticks on every cycle. Codes 010 to 111 tick once every 8, 32, 64, 128, 256 and 1024 cycles, taken from a free-running divider.
- R11: In single-slope PWM the counter runs 0 to 255 and wraps. At the wrap, action 10 sets the latch and action 11 clears it. On a match, action 10 clears the latch and action 11 sets it.
- R12: In dual-slope PWM the counter counts up to 255 and then down to 0. With action 10, a match while counting up clears the latch and a match while counting down sets it. Action 11 does the opposite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| irq_ack | input | 1 | Interrupt-serviced pulse; clears the match flag |
| irq | output | 1 | Interrupt request (match flag) |
| wave_out | output | 1 | Waveform output pin |

## Verification
If the output latch is wrong, the pin shows it in the cycle after the event that caused it, whether that event is a forced strobe, a match or a wrap. A mis-decoded mode bit therefore shows up as the wrong pin level right after a force write. If the count or direction register is wrong, the counter readback shows it within one tick. In dual-slope mode the error also appears as a pin edge at the wrong turn point. A flag register that is set or held by mistake shows directly on `irq` and on the flags readback one cycle later. The same readback reveals a forced compare that has leaked into the flag path.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  localparam int PSC_W = 10;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_CMP  = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_DUAL = 2'b01,
    MODE_CLR  = 2'b10,
    MODE_FAST = 2'b11
  } tmode_e;

  // mode value is {bit3, bit6} of the control byte
  function automatic tmode_e mode_of(input logic b3, input logic b6);
    return tmode_e'({b3, b6});
  endfunction

  function automatic logic is_pwm(input tmode_e m);
    return (m == MODE_DUAL) || (m == MODE_FAST);
  endfunction

  // non-PWM output action
  function automatic logic act_next(input logic [1:0] act, input logic cur);
    case (act)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  function automatic logic div_tick(input logic [2:0] cs, input logic [PSC_W-1:0] p);
    case (cs)
      3'd0:    return 1'b0;
      3'd1:    return 1'b1;
      3'd2:    return &p[2:0];
      3'd3:    return &p[4:0];
      3'd4:    return &p[5:0];
      3'd5:    return &p[6:0];
      3'd6:    return &p[7:0];
      default: return &p[9:0];
    endcase
  endfunction

endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
  import tmr8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cs,
  output logic       tick
);
  logic [PSC_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign tick = div_tick(cs, div_q);
endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  tmode_e        mode,
  input  logic [DW-1:0] cmp,
  input  logic          cnt_wr,
  input  logic [DW-1:0] cnt_wdata,
  output logic [DW-1:0] count,
  output logic          up,
  output logic          match_evt,
  output logic          ovf_evt,
  output logic          bottom_evt
);
  localparam logic [DW-1:0] MAXV = '1;

  logic [DW-1:0] count_q, next_count;
  logic          up_q, eq, at_max, at_zero, at_turn, step;

  assign eq      = (count_q == cmp);
  assign at_max  = (count_q == MAXV);
  assign at_zero = (count_q == '0);
  assign at_turn = up_q ? at_max : at_zero;
  assign step    = tick && !cnt_wr;

  always_comb begin
    case (mode)
      MODE_CLR:  next_count = eq ? '0 : count_q + 1'b1;
      MODE_DUAL: begin
        if (up_q) next_count = at_max  ? count_q - 1'b1 : count_q + 1'b1;
        else      next_count = at_zero ? count_q + 1'b1 : count_q - 1'b1;
      end
      default:   next_count = count_q + 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      up_q    <= 1'b1;
    end else begin
      if (cnt_wr)    count_q <= cnt_wdata;
      else if (tick) count_q <= next_count;
      if (mode != MODE_DUAL)  up_q <= 1'b1;
      else if (step && at_turn) up_q <= !up_q;
    end
  end

  assign match_evt  = step && eq;
  assign ovf_evt    = step && ((mode == MODE_DUAL) ? (!up_q && at_zero) : at_max);
  assign bottom_evt = step && (mode == MODE_FAST) && at_max;
  assign count      = count_q;
  assign up         = up_q;

  a_r6_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    step && mode == MODE_CLR && count_q == cmp |=> count_q == '0);
  a_r7_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    step && mode == MODE_FREE && count_q == MAXV |=> count_q == '0);
  a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cnt_wr |=> count_q == $past(count_q));
  a_r12_turn_down: assert property (@(posedge clk) disable iff (!rst_n)
    step && mode == MODE_DUAL && up_q && at_max |=> count_q == MAXV - 1'b1);
endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
  import tmr8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  tmode_e     mode,
  input  logic [1:0] act,
  input  logic       match_evt,
  input  logic       bottom_evt,
  input  logic       up,
  input  logic       force_req,
  input  tmode_e     force_mode,
  input  logic [1:0] force_act,
  output logic       wave
);
  logic oc_q, oc_d, force_hit, pwm_on;

  assign force_hit = force_req && !is_pwm(force_mode);
  assign pwm_on    = is_pwm(mode);

  always_comb begin
    oc_d = oc_q;
    if (force_hit) begin
      oc_d = act_next(force_act, oc_q);
    end else if (!pwm_on) begin
      if (match_evt) oc_d = act_next(act, oc_q);
    end else if (act[1]) begin
      if (mode == MODE_FAST) begin
        if (bottom_evt)     oc_d = !act[0];
        else if (match_evt) oc_d = act[0];
      end else if (match_evt) begin
        oc_d = up ? act[0] : !act[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) oc_q <= 1'b0;
    else        oc_q <= oc_d;
  end

  assign wave = (act != 2'b00) && !(pwm_on && act == 2'b01) && oc_q;

  a_r5_pwm_force_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    force_req && is_pwm(force_mode) && !match_evt && !bottom_evt |=> $stable(oc_q));
  a_r3_force_set: assert property (@(posedge clk) disable iff (!rst_n)
    force_req && !is_pwm(force_mode) && force_act == 2'b11 |=> oc_q);
  a_r3_force_clear: assert property (@(posedge clk) disable iff (!rst_n)
    force_req && !is_pwm(force_mode) && force_act == 2'b10 |=> !oc_q);
endmodule

// File: rtl/tmr8_forced.sv
module tmr8_forced
  import tmr8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          irq_ack,
  output logic          irq,
  output logic          wave_out
);
  logic [6:0]    ctrl_q;
  logic [DW-1:0] cmp_q, count;
  logic          mflag_q, oflag_q;
  logic          tick, up, match_evt, ovf_evt, bottom_evt;
  logic          wr_ctrl, wr_cnt, wr_cmp, wr_flag, force_req;
  tmode_e        mode, force_mode;

  assign wr_ctrl    = bus_wr && bus_addr == A_CTRL;
  assign wr_cnt     = bus_wr && bus_addr == A_CNT;
  assign wr_cmp     = bus_wr && bus_addr == A_CMP;
  assign wr_flag    = bus_wr && bus_addr == A_FLAG;
  assign force_req  = wr_ctrl && bus_wdata[7];
  assign force_mode = mode_of(bus_wdata[3], bus_wdata[6]);
  assign mode       = mode_of(ctrl_q[3], ctrl_q[6]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cmp_q   <= '0;
      mflag_q <= 1'b0;
      oflag_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[6:0];
      if (wr_cmp)  cmp_q  <= bus_wdata;
      if (match_evt)                            mflag_q <= 1'b1;
      else if ((wr_flag && bus_wdata[0]) || irq_ack) mflag_q <= 1'b0;
      if (ovf_evt)                       oflag_q <= 1'b1;
      else if (wr_flag && bus_wdata[1])  oflag_q <= 1'b0;
    end
  end

  tmr8_prescaler u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .cs   (ctrl_q[2:0]),
    .tick (tick)
  );

  tmr8_counter #(.DW(DW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .mode      (mode),
    .cmp       (cmp_q),
    .cnt_wr    (wr_cnt),
    .cnt_wdata (bus_wdata),
    .count     (count),
    .up        (up),
    .match_evt (match_evt),
    .ovf_evt   (ovf_evt),
    .bottom_evt(bottom_evt)
  );

  tmr8_wave u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .act       (ctrl_q[5:4]),
    .match_evt (match_evt),
    .bottom_evt(bottom_evt),
    .up        (up),
    .force_req (force_req),
    .force_mode(force_mode),
    .force_act (bus_wdata[5:4]),
    .wave      (wave_out)
  );

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = DW'({1'b0, ctrl_q});
      A_CNT:   bus_rdata = count;
      A_CMP:   bus_rdata = cmp_q;
      default: bus_rdata = DW'({oflag_q, mflag_q});
    endcase
  end

  assign irq = mflag_q;

  a_r4_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    force_req && !match_evt && !mflag_q |=> !irq);
  a_r9_write_blocks_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt && !mflag_q |=> !mflag_q);
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !match_evt |=> !irq);
endmodule

// File: tb/tb_tmr8_forced.sv
module tb_tmr8_forced;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_ack = 1'b0;
  logic       irq, wave_out;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tmr8_forced dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
    .irq(irq), .wave_out(wave_out)
  );

  // {control byte written, expected pin afterwards}; timer stopped throughout
  localparam logic [8:0] VEC [0:13] = '{
    {8'h00, 1'b0}, {8'h30, 1'b0}, {8'hB0, 1'b1}, {8'hA0, 1'b0},
    {8'h90, 1'b1}, {8'h90, 1'b0}, {8'h90, 1'b1}, {8'h80, 1'b0},
    {8'h10, 1'b1}, {8'hE0, 1'b1}, {8'hA8, 1'b0}, {8'hB8, 1'b1},
    {8'hD8, 1'b0}, {8'h38, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic window(input logic [2:0] cs, input int cycles, input int exp_ticks, input string req);
    logic [7:0] a, b;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, {5'b0, cs});
    rd(2'd1, a);
    repeat (cycles) @(negedge clk);
    rd(2'd1, b);
    chk(req, b - a, 8'(exp_ticks));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v);
      chk("R1 register", v, 8'h00);
    end
    chk("R1 wave", {7'b0, wave_out}, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R2 R3 R4 R5 table with stopped timer
    wr(2'd1, 8'd77);
    foreach (VEC[i]) begin
      wr(2'd0, VEC[i][8:1]);
      chk("R3/R5 pin", {7'b0, wave_out}, {7'b0, VEC[i][0]});
      rd(2'd0, v); chk("R2 control readback", v, VEC[i][8:1] & 8'h7F);
      rd(2'd3, v); chk("R4 flags after force", v, 8'h00);
      rd(2'd1, v); chk("R4 counter after force", v, 8'd77);
    end

    // R4 force in clear-on-match with counter equal to compare
    wr(2'd0, 8'h00); wr(2'd2, 8'd5); wr(2'd1, 8'd5);
    wr(2'd0, 8'hA8);
    rd(2'd1, v); chk("R4 count kept", v, 8'd5);
    chk("R4 no irq", {7'b0, irq}, 8'h00);

    // R6 clear-on-match, toggle action
    wr(2'd1, 8'd0); wr(2'd3, 8'h03);
    wr(2'd0, 8'h19);
    repeat (5) @(negedge clk);
    rd(2'd1, v); chk("R6 count at top", v, 8'd5);
    chk("R6 pin before match", {7'b0, wave_out}, 8'h00);
    @(negedge clk);
    rd(2'd1, v); chk("R6 count cleared", v, 8'd0);
    rd(2'd3, v); chk("R6 match flag", v, 8'h01);
    chk("R6 irq", {7'b0, irq}, 8'h01);
    chk("R6 pin toggled", {7'b0, wave_out}, 8'h01);
    wr(2'd0, 8'h08);

    // R8 write-one clear, then ack clear
    wr(2'd3, 8'h01);
    chk("R8 w1c irq", {7'b0, irq}, 8'h00);
    wr(2'd1, 8'd4);
    wr(2'd0, 8'h09);
    wr(2'd0, 8'h08);
    chk("R8 flag set again", {7'b0, irq}, 8'h01);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R8 ack clears irq", {7'b0, irq}, 8'h00);

    // R9 counter write blocks a match
    wr(2'd0, 8'h00); wr(2'd2, 8'd20); wr(2'd1, 8'd19); wr(2'd3, 8'h03);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'd50);
    rd(2'd1, v); chk("R9 written value", v, 8'd50);
    rd(2'd3, v); chk("R9 no match flag", v, 8'h00);
    wr(2'd0, 8'h00);

    // R7 free-running wrap
    wr(2'd2, 8'd100); wr(2'd1, 8'd254); wr(2'd3, 8'h03);
    wr(2'd0, 8'h01);
    @(negedge clk);
    rd(2'd1, v); chk("R7 count 255", v, 8'd255);
    @(negedge clk);
    rd(2'd1, v); chk("R7 wrapped", v, 8'd0);
    rd(2'd3, v); chk("R7 overflow flag", v, 8'h02);
    chk("R7 irq only from match", {7'b0, irq}, 8'h00);
    wr(2'd0, 8'h00);

    // R10 clock select rates
    window(3'd1, 40, 40, "R10 undivided");
    window(3'd2, 64, 8, "R10 div8");
    window(3'd3, 64, 2, "R10 div32");
    window(3'd4, 128, 2, "R10 div64");
    window(3'd7, 1024, 1, "R10 div1024");
    window(3'd0, 30, 0, "R10 stopped");

    // R11 single-slope PWM, action 10
    wr(2'd0, 8'h00); wr(2'd2, 8'd3); wr(2'd0, 8'hA0); wr(2'd1, 8'd253);
    wr(2'd0, 8'h69);
    repeat (2) @(negedge clk);
    chk("R11 low before wrap", {7'b0, wave_out}, 8'h00);
    @(negedge clk);
    chk("R11 set at wrap", {7'b0, wave_out}, 8'h01);
    repeat (3) @(negedge clk);
    chk("R11 high until match", {7'b0, wave_out}, 8'h01);
    @(negedge clk);
    chk("R11 cleared on match", {7'b0, wave_out}, 8'h00);
    wr(2'd0, 8'h00);

    // R12 dual-slope PWM, action 10
    wr(2'd2, 8'd253); wr(2'd0, 8'hB0); wr(2'd1, 8'd251);
    wr(2'd0, 8'h61);
    repeat (2) @(negedge clk);
    chk("R12 high before up match", {7'b0, wave_out}, 8'h01);
    @(negedge clk);
    chk("R12 cleared on up match", {7'b0, wave_out}, 8'h00);
    repeat (2) @(negedge clk);
    rd(2'd1, v); chk("R12 turned down", v, 8'd254);
    @(negedge clk);
    chk("R12 low before down match", {7'b0, wave_out}, 8'h00);
    @(negedge clk);
    chk("R12 set on down match", {7'b0, wave_out}, 8'h01);
    rd(2'd1, v); chk("R12 counting down", v, 8'd252);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule